// File: doc/BRIEF.md
# Per-Instruction Local Access History

This block keeps a small set of access-history buffers, each owned by one instruction address. Each buffer holds a time-ordered list of recently touched data addresses for its instruction, and each stored address carries a cache-level mark: L1 or L2. An access record arrives with an instruction address, a data address and a level flag. The block then does four things:

- It picks the buffer that belongs to the instruction, or reclaims the least recently used buffer when no buffer belongs to it.
- It inserts the data address only if the buffer does not already hold it.
- It upgrades an existing L1 mark to L2 when a matching L2 access arrives.
- It drops the oldest entry when a full buffer receives a new address.

One cycle after each access, the block reports whether the access changed the history ("added"). Pattern-detection logic further downstream uses that report to decide when to run. The same report also gives the selected buffer index and says whether the instruction already owned a buffer. Two running counters count buffer hits and buffer reclaims.

Top module: `lhb_local_hist`

## Requirements
- R1: After reset, `res_valid` is 0, both counters are 0 and no buffer is owned, so the first access of any instruction address is reported as a miss.
- R2: Every accepted access (`acc_valid`=1 at a rising edge) produces exactly one result with `res_valid`=1 in the cycle after that edge. `res_valid` is 0 in all other cycles.
- R3: An instruction address that owns no buffer takes the least recently used buffer. It reports `res_hit`=0 and increments `miss_cnt` by one. Straight after reset, buffers are claimed in index order 0, 1, 2, and so on.
- R4: An instruction address that owns a buffer reports `res_hit`=1 and that buffer's index in `res_buf`, and increments `hit_cnt` by one.
- R5: After every access, the selected buffer becomes most recently used, whether the access hit or reclaimed a buffer.
- R6: A data address already present in the selected buffer adds no entry and reports `res_added`=0. The only exception is the upgrade case in R7.
- R7: A present address whose stored level is L1 (`acc_l2`=0 when written) is changed to L2 when an access with `acc_l2`=1 arrives, and that access reports `res_added`=1. A later L2 access to the same address reports 0.
- R8: A data address not present in the selected buffer is inserted and reports `res_added`=1.
- R9: A buffer holds at most DEPTH entries (default 16). A new address arriving at a full buffer evicts the oldest entry first.
- R10: A reclaimed buffer is emptied before use, so none of the previous owner's addresses remain in it.
- R11: A cycle with `acc_valid`=0 changes neither counter nor any buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access record present this cycle |
| acc_pc | input | PC_W | Instruction address of the access |
| acc_addr | input | ADDR_W | Data address of the access |
| acc_l2 | input | 1 | Level flag: 1 = L2, 0 = L1 |
| res_valid | output | 1 | Result for the previous cycle's access |
| res_hit | output | 1 | Instruction already owned a buffer |
| res_added | output | 1 | History changed (insert or upgrade) |
| res_buf | output | IDX_W | Index of the selected buffer |
| hit_cnt | output | CNT_W | Running count of buffer hits |
| miss_cnt | output | CNT_W | Running count of buffer reclaims |

## Verification
Buffer lookup, LRU update and insertion all take place at the edge that accepts the access. The result flags, the buffer index and both counters therefore change in the one cycle after that edge, and they stay stable until the next accepted access. The bench drives each record on a falling edge and samples the outputs one time unit after the following rising edge. Because the history updates at the same edge, a record sent right after that edge already sees the updated state. Idle behaviour is checked by sampling the outputs across several cycles in which no access is sent.

// File: rtl/lhb_pkg.sv
package lhb_pkg;
  typedef enum logic {
    LVL_L1 = 1'b0,
    LVL_L2 = 1'b1
  } lvl_e;

  localparam int DEF_NUM_BUF = 8;
  localparam int DEF_DEPTH   = 16;
  localparam int DEF_WORD_W  = 32;
endpackage

// File: rtl/lhb_owner_lru.sv
module lhb_owner_lru #(
  parameter int NUM_BUF = 8,
  parameter int PC_W    = 32,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [PC_W-1:0]  acc_pc,
  output logic             own_hit,
  output logic [IDX_W-1:0] sel_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_BUF - 1);

  logic [PC_W-1:0]  tag_q   [NUM_BUF];
  logic [PC_W-1:0]  tag_d   [NUM_BUF];
  logic [IDX_W-1:0] age_q   [NUM_BUF];
  logic [IDX_W-1:0] age_d   [NUM_BUF];
  logic [NUM_BUF-1:0] vld_q, vld_d, match;
  logic [IDX_W-1:0] hit_idx, victim_idx, sel_age;

  always_comb begin
    hit_idx    = '0;
    victim_idx = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      match[i] = vld_q[i] && (tag_q[i] == acc_pc);
      if (match[i]) hit_idx = IDX_W'(i);
      if (age_q[i] == OLDEST) victim_idx = IDX_W'(i);
    end
    own_hit = |match;
    sel_idx = own_hit ? hit_idx : victim_idx;
    sel_age = age_q[sel_idx];
  end

  always_comb begin
    for (int i = 0; i < NUM_BUF; i++) begin
      tag_d[i] = tag_q[i];
      age_d[i] = age_q[i];
      vld_d[i] = vld_q[i];
      if (IDX_W'(i) == sel_idx) begin
        tag_d[i] = acc_pc;
        age_d[i] = '0;
        vld_d[i] = 1'b1;
      end else if (age_q[i] < sel_age) begin
        age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NUM_BUF; i++) age_q[i] <= IDX_W'(NUM_BUF - 1 - i);
    end else if (acc_valid) begin
      vld_q <= vld_d;
      for (int i = 0; i < NUM_BUF; i++) age_q[i] <= age_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (acc_valid) begin
      for (int i = 0; i < NUM_BUF; i++) tag_q[i] <= tag_d[i];
    end
  end
endmodule

// File: rtl/lhb_hist_buf.sv
module lhb_hist_buf
  import lhb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              upg,
  input  logic [ADDR_W-1:0] in_addr,
  input  lvl_e              in_lvl,
  output logic              present,
  output logic              stored_l2
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [ADDR_W-1:0] addr_d [DEPTH];
  logic [DEPTH-1:0]  lvl_q, lvl_d, vld_q, vld_d, hitv;
  logic              wr_en;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) hitv[k] = vld_q[k] && (addr_q[k] == in_addr);
    present   = |hitv;
    stored_l2 = |(hitv & lvl_q);
  end

  assign wr_en = clr | push | upg;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      addr_d[k] = addr_q[k];
      lvl_d[k]  = lvl_q[k] | (upg & hitv[k]);
      vld_d[k]  = vld_q[k] & ~clr;
    end
    if (push) begin
      for (int k = DEPTH - 1; k > 0; k--) begin
        addr_d[k] = addr_q[k-1];
        lvl_d[k]  = lvl_q[k-1];
        vld_d[k]  = vld_q[k-1] & ~clr;
      end
      addr_d[0] = in_addr;
      lvl_d[0]  = (in_lvl == LVL_L2);
      vld_d[0]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      lvl_q <= lvl_d;
      for (int k = 0; k < DEPTH; k++) addr_q[k] <= addr_d[k];
    end
  end
endmodule

// File: rtl/lhb_local_hist.sv
module lhb_local_hist
  import lhb_pkg::*;
#(
  parameter int NUM_BUF = DEF_NUM_BUF,
  parameter int DEPTH   = DEF_DEPTH,
  parameter int PC_W    = DEF_WORD_W,
  parameter int ADDR_W  = DEF_WORD_W,
  parameter int CNT_W   = 16,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_l2,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_added,
  output logic [IDX_W-1:0]  res_buf,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  miss_cnt
);
  logic             own_hit;
  logic [IDX_W-1:0] sel_idx;
  logic [NUM_BUF-1:0] buf_pres, buf_l2, clr_v, push_v, upg_v;
  logic             present, upgrade, added;
  lvl_e             in_lvl;

  assign in_lvl = acc_l2 ? LVL_L2 : LVL_L1;

  lhb_owner_lru #(.NUM_BUF(NUM_BUF), .PC_W(PC_W), .IDX_W(IDX_W)) owner_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pc(acc_pc),
    .own_hit(own_hit), .sel_idx(sel_idx)
  );

  always_comb begin
    present = own_hit & buf_pres[sel_idx];
    upgrade = present & acc_l2 & ~buf_l2[sel_idx];
    added   = ~present | upgrade;
    for (int i = 0; i < NUM_BUF; i++) begin
      clr_v[i]  = acc_valid & (sel_idx == IDX_W'(i)) & ~own_hit;
      push_v[i] = acc_valid & (sel_idx == IDX_W'(i)) & ~present;
      upg_v[i]  = acc_valid & (sel_idx == IDX_W'(i)) & upgrade;
    end
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    lhb_hist_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) hist_i (
      .clk(clk), .rst_n(rst_n), .clr(clr_v[g]), .push(push_v[g]), .upg(upg_v[g]),
      .in_addr(acc_addr), .in_lvl(in_lvl),
      .present(buf_pres[g]), .stored_l2(buf_l2[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_added <= 1'b0;
      res_buf   <= '0;
      hit_cnt   <= '0;
      miss_cnt  <= '0;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_hit   <= own_hit;
        res_added <= added;
        res_buf   <= sel_idx;
        if (own_hit) hit_cnt  <= hit_cnt + 1'b1;
        else         miss_cnt <= miss_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lhb_local_hist_chk.sv
module lhb_local_hist_chk #(
  parameter int NUM_BUF = 8,
  parameter int CNT_W   = 16,
  parameter int IDX_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             res_valid,
  input logic             res_hit,
  input logic             res_added,
  input logic [IDX_W-1:0] res_buf,
  input logic [CNT_W-1:0] hit_cnt,
  input logic [CNT_W-1:0] miss_cnt
);
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !res_valid);
  a_r4_hit_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (hit_cnt == CNT_W'($past(hit_cnt) + 1'b1)));
  a_r3_miss_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (miss_cnt == CNT_W'($past(miss_cnt) + 1'b1)));
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(hit_cnt) && $stable(miss_cnt)));
  a_r10_reclaim_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> res_added);
  a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (int'(res_buf) < NUM_BUF));
endmodule

bind lhb_local_hist lhb_local_hist_chk #(.NUM_BUF(NUM_BUF), .CNT_W(CNT_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .res_valid(res_valid),
  .res_hit(res_hit), .res_added(res_added), .res_buf(res_buf),
  .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
);

// File: tb/lhb_local_hist_tb_top.sv
`timescale 1ns/1ps
module lhb_local_hist_tb_top;
  localparam int NB = 8;
  localparam int DP = 16;
  localparam int IW = 3;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_valid;
  logic [31:0]   acc_pc, acc_addr;
  logic          acc_l2;
  logic          res_valid, res_hit, res_added;
  logic [IW-1:0] res_buf;
  logic [CW-1:0] hit_cnt, miss_cnt;

  int checks = 0;
  int errors = 0;
  int exp_hits = 0;
  int exp_miss = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lhb_local_hist #(.NUM_BUF(NB), .DEPTH(DP), .PC_W(32), .ADDR_W(32), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pc(acc_pc),
    .acc_addr(acc_addr), .acc_l2(acc_l2), .res_valid(res_valid), .res_hit(res_hit),
    .res_added(res_added), .res_buf(res_buf), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic access(input int pc, input int addr, input bit l2, input bit e_hit,
                        input int e_buf, input bit e_added, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_pc = pc; acc_addr = addr; acc_l2 = l2;
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
    if (e_hit) exp_hits++; else exp_miss++;
    chk("R2", "res_valid", int'(res_valid), 1);
    chk(req, "res_hit", int'(res_hit), int'(e_hit));
    chk(req, "res_buf", int'(res_buf), e_buf);
    chk(req, "res_added", int'(res_added), int'(e_added));
    chk("R4", "hit_cnt", int'(hit_cnt), exp_hits);
    chk("R3", "miss_cnt", int'(miss_cnt), exp_miss);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "res_valid", int'(res_valid), 0);
    chk("R1", "hit_cnt", int'(hit_cnt), 0);
    chk("R1", "miss_cnt", int'(miss_cnt), 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < NB; i++) access(100 + i, 32'h1000, 1'b0, 1'b0, i, 1'b1, "R3");
    access(100, 32'h1040, 1'b0, 1'b1, 0, 1'b1, "R8");
  endtask

  task automatic t_dedup();
    access(100, 32'h1000, 1'b0, 1'b1, 0, 1'b0, "R6");
    access(100, 32'h1000, 1'b1, 1'b1, 0, 1'b1, "R7");
    access(100, 32'h1000, 1'b1, 1'b1, 0, 1'b0, "R7");
    access(100, 32'h1000, 1'b0, 1'b1, 0, 1'b0, "R6");
  endtask

  task automatic t_lru();
    // LRU order now: buffer 1 oldest, then 2, 3, ...
    access(200, 32'h2000, 1'b0, 1'b0, 1, 1'b1, "R5");
    access(107, 32'h1000, 1'b0, 1'b1, 7, 1'b0, "R5");
    // pc 101 lost its buffer; buffer 2 (pc 102, holds 0x1000) is reclaimed
    access(101, 32'h1000, 1'b0, 1'b0, 2, 1'b1, "R10");
    access(101, 32'h1000, 1'b0, 1'b1, 2, 1'b0, "R6");
  endtask

  task automatic t_evict();
    access(300, 32'h100, 1'b0, 1'b0, 3, 1'b1, "R3");
    for (int k = 2; k <= DP; k++) access(300, 32'h100 * k, 1'b0, 1'b1, 3, 1'b1, "R8");
    access(300, 32'h100, 1'b0, 1'b1, 3, 1'b0, "R9");
    access(300, 32'h100 * (DP + 1), 1'b0, 1'b1, 3, 1'b1, "R9");
    access(300, 32'h100, 1'b0, 1'b1, 3, 1'b1, "R9");
    access(300, 32'h100 * 3, 1'b0, 1'b1, 3, 1'b0, "R9");
    access(300, 32'h100 * 2, 1'b0, 1'b1, 3, 1'b1, "R9");
  endtask

  task automatic t_idle();
    for (int c = 0; c < 5; c++) begin
      @(posedge clk);
      #1;
      chk("R11", "res_valid", int'(res_valid), 0);
      chk("R11", "hit_cnt", int'(hit_cnt), exp_hits);
      chk("R11", "miss_cnt", int'(miss_cnt), exp_miss);
    end
    access(300, 32'h100 * 2, 1'b0, 1'b1, 3, 1'b0, "R11");
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_pc = '0; acc_addr = '0; acc_l2 = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_fill();
    t_dedup();
    t_lru();
    t_evict();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule